// File: doc/BRIEF.md
# Configurable Burst WAIT Generator

This block sits on the memory side of a synchronous burst pseudo-SRAM port and decides, cycle by cycle, whether the beat on the data bus is valid. Data is invalid while the initial access latency runs down, for one cycle when the burst crosses a row boundary, and for a fixed window when an internal refresh collides with the burst. From these conditions it produces a data-valid strobe for the datapath and the level of the WAIT pin seen by the host. The same rules apply to read and write bursts.

A configuration register holds three settings: the WAIT polarity, the WAIT timing (leading the data by one clock or aligned with it), and the access latency. The invalid state is computed one cycle ahead. The data-valid strobe is a registered copy of that look-ahead. WAIT follows the look-ahead in leading mode and the registered copy in aligned mode. Outside synchronous mode the pin carries no status and is held at its asserted level. Dropping chip enable ends the burst.

All control and status pins are plain levels or one-cycle pulses. No data stream passes through the block, so it has no valid/ready handshake and applies no back-pressure.

Top module: `burst_wait_gen`

## Requirements
- R1: After reset the configuration is: polarity active high, timing leading, latency 3. With chip enable low, `data_valid` is low and, in synchronous mode, `wait_o` is low (the deasserted level).
- R2: A clock edge with `cfg_we` high loads `cfg_wr_pol`, `cfg_wr_lead` and `cfg_wr_lat` into the configuration. The new values govern every later burst.
- R3: Call the edge that samples `burst_start` with `chip_en` and `sync_mode` high edge 0. `data_valid` first rises on edge L, where L is the latency. Latency codes 0 and 1 act as 2, and the largest code is 7.
- R4: In leading mode (`cfg_wr_lead`=1), WAIT asserts on edge 0 and deasserts on edge L-1. In general, each WAIT change comes one edge before the matching change of `data_valid`.
- R5: In aligned mode (`cfg_wr_lead`=0), from edge 1 onward during a burst, WAIT is asserted exactly when `data_valid` is low. WAIT stays deasserted after edge 0, and it is never asserted while `data_valid` is high.
- R6: A row holds 128 words. A valid beat at an address whose low 7 bits are all ones is followed by exactly one invalid cycle before the next beat.
- R7: If `refresh_req` is sampled high while a burst is running, the look-ahead is invalid for the next four cycles, so `data_valid` is low for four consecutive edges starting one edge later. If no burst is running, `refresh_req` has no effect.
- R8: With polarity 0, WAIT is active low: the pin reads 1 when deasserted and 0 when asserted.
- R9: While `sync_mode` is low, `wait_o` is held at the asserted level, `data_valid` stays low, and `burst_start` is ignored.
- R10: An edge that samples `chip_en` low ends the burst. After that edge `data_valid` is low and WAIT is deasserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Burst clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Load configuration fields |
| cfg_wr_pol | input | 1 | WAIT polarity: 1 active high, 0 active low |
| cfg_wr_lead | input | 1 | WAIT timing: 1 leads data by one clock, 0 aligned |
| cfg_wr_lat | input | 3 | Access latency in clocks (2 to 7) |
| sync_mode | input | 1 | 1 synchronous burst mode, 0 asynchronous/page mode |
| chip_en | input | 1 | Chip enable, active high |
| burst_start | input | 1 | One-cycle pulse that begins a burst |
| start_addr | input | ADDR_W | Word address of the first beat |
| refresh_req | input | 1 | Internal refresh collision request |
| data_valid | output | 1 | Current beat on the bus is valid |
| wait_o | output | 1 | WAIT pin level |

## Verification
The assertions check the relations that must hold on every cycle. In asynchronous mode the pin sits at the asserted level and the strobe is low. A leading WAIT always precedes an invalid beat. An aligned WAIT is never asserted alongside valid data. Dropping chip enable clears both outputs. A refresh collision always produces an invalid beat two edges later. The exact edge numbers depend on counts, so only the bench's scenarios can show them: the latency countdown for several codes including the clamped ones, the single row-end bubble at address 127, the four-cycle refresh window, and the inverted pin levels under polarity 0.

// File: rtl/bwg_pkg.sv
package bwg_pkg;
  localparam int LAT_W = 3;
  localparam logic [LAT_W-1:0] LAT_FLOOR = 3'd2;
  localparam logic [LAT_W-1:0] LAT_RST   = 3'd3;

  typedef struct packed {
    logic             pol;   // 1: WAIT active high
    logic             lead;  // 1: WAIT one clock ahead of data
    logic [LAT_W-1:0] lat;   // access latency in clocks
  } bwg_cfg_t;

  localparam bwg_cfg_t CFG_RST = '{pol: 1'b1, lead: 1'b1, lat: LAT_RST};

  function automatic logic [LAT_W-1:0] clamp_lat(input logic [LAT_W-1:0] l);
    return (l < LAT_FLOOR) ? LAT_FLOOR : l;
  endfunction
endpackage

// File: rtl/bwg_cfg_reg.sv
module bwg_cfg_reg
  import bwg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             pol_in,
  input  logic             lead_in,
  input  logic [LAT_W-1:0] lat_in,
  output bwg_cfg_t         cfg_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= CFG_RST;
    end else if (we) begin
      cfg_q.pol  <= pol_in;
      cfg_q.lead <= lead_in;
      cfg_q.lat  <= clamp_lat(lat_in);
    end
  end
endmodule

// File: rtl/bwg_stall_ctrl.sv
module bwg_stall_ctrl
  import bwg_pkg::*;
#(
  parameter int ADDR_W    = 23,
  parameter int ROW_WORDS = 128,
  parameter int REF_CYC   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_mode,
  input  logic              chip_en,
  input  logic              burst_start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              refresh_req,
  input  logic [LAT_W-1:0]  lat,
  output logic              active,
  output logic              la_valid
);
  localparam int ROW_LSB = $clog2(ROW_WORDS);
  localparam int RC_W    = $clog2(REF_CYC + 1);

  logic [LAT_W-1:0]  stall_cnt;
  logic [RC_W-1:0]   ref_cnt;
  logic [ADDR_W-1:0] beat_addr;
  logic              row_end;

  // look-ahead: the beat launched this cycle is valid at the next edge
  assign la_valid = active && (stall_cnt == '0) && (ref_cnt == '0);
  assign row_end  = &beat_addr[ROW_LSB-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      stall_cnt <= '0;
      ref_cnt   <= '0;
      beat_addr <= '0;
    end else if (!chip_en || !sync_mode) begin
      active    <= 1'b0;
      stall_cnt <= '0;
      ref_cnt   <= '0;
    end else if (burst_start) begin
      active    <= 1'b1;
      stall_cnt <= lat - LAT_W'(1);
      ref_cnt   <= '0;
      beat_addr <= start_addr;
    end else if (active) begin
      if (refresh_req)
        ref_cnt <= RC_W'(REF_CYC);
      else if (ref_cnt != '0)
        ref_cnt <= ref_cnt - RC_W'(1);
      if (la_valid) begin
        beat_addr <= beat_addr + ADDR_W'(1);
        if (row_end) stall_cnt <= LAT_W'(1);
      end else if (stall_cnt != '0) begin
        stall_cnt <= stall_cnt - LAT_W'(1);
      end
    end
  end
endmodule

// File: rtl/bwg_wait_out.sv
module bwg_wait_out (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_mode,
  input  logic chip_en,
  input  logic active,
  input  logic la_valid,
  input  logic pol,
  input  logic lead,
  output logic data_valid,
  output logic wait_o
);
  logic inv_la;     // invalid beat ahead, inside a burst
  logic inv_q;      // registered copy, aligned with data_valid
  logic asserted;

  assign inv_la = active && !la_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_valid <= 1'b0;
      inv_q      <= 1'b0;
    end else begin
      data_valid <= chip_en && sync_mode && la_valid;
      inv_q      <= chip_en && sync_mode && inv_la;
    end
  end

  assign asserted = !sync_mode || (lead ? inv_la : inv_q);
  assign wait_o   = pol ? asserted : !asserted;
endmodule

// File: rtl/burst_wait_gen.sv
module burst_wait_gen
  import bwg_pkg::*;
#(
  parameter int ADDR_W    = 23,
  parameter int ROW_WORDS = 128,
  parameter int REF_CYC   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_wr_pol,
  input  logic              cfg_wr_lead,
  input  logic [LAT_W-1:0]  cfg_wr_lat,
  input  logic              sync_mode,
  input  logic              chip_en,
  input  logic              burst_start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              refresh_req,
  output logic              data_valid,
  output logic              wait_o
);
  bwg_cfg_t cfg_q;
  logic     active;
  logic     la_valid;
  logic     pol_lvl;
  logic     lead_sel;

  assign pol_lvl  = cfg_q.pol;
  assign lead_sel = cfg_q.lead;

  bwg_cfg_reg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (cfg_we),
    .pol_in  (cfg_wr_pol),
    .lead_in (cfg_wr_lead),
    .lat_in  (cfg_wr_lat),
    .cfg_q   (cfg_q)
  );

  bwg_stall_ctrl #(
    .ADDR_W    (ADDR_W),
    .ROW_WORDS (ROW_WORDS),
    .REF_CYC   (REF_CYC)
  ) u_stall (
    .clk         (clk),
    .rst_n       (rst_n),
    .sync_mode   (sync_mode),
    .chip_en     (chip_en),
    .burst_start (burst_start),
    .start_addr  (start_addr),
    .refresh_req (refresh_req),
    .lat         (cfg_q.lat),
    .active      (active),
    .la_valid    (la_valid)
  );

  bwg_wait_out u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_mode  (sync_mode),
    .chip_en    (chip_en),
    .active     (active),
    .la_valid   (la_valid),
    .pol        (pol_lvl),
    .lead       (lead_sel),
    .data_valid (data_valid),
    .wait_o     (wait_o)
  );
endmodule

// File: rtl/bwg_chk.sv
module bwg_chk (
  input logic clk,
  input logic rst_n,
  input logic sync_mode,
  input logic chip_en,
  input logic burst_start,
  input logic refresh_req,
  input logic active,
  input logic pol,
  input logic lead,
  input logic data_valid,
  input logic wait_o
);
  // R9
  async_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_mode |-> wait_o == pol);

  // R9
  async_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_mode |=> !data_valid);

  // R4
  lead_before_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && lead && wait_o == pol) |=> !data_valid);

  // R5
  aligned_no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && !lead && data_valid) |-> wait_o != pol);

  // R10
  ce_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en |=> (!data_valid && (!sync_mode || wait_o != pol)));

  // R3
  first_beat_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_start && chip_en && sync_mode) |=> !data_valid);

  // R7
  refresh_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_req && active && chip_en && sync_mode && !burst_start) |=> ##1 !data_valid);
endmodule

bind burst_wait_gen bwg_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sync_mode   (sync_mode),
  .chip_en     (chip_en),
  .burst_start (burst_start),
  .refresh_req (refresh_req),
  .active      (active),
  .pol         (pol_lvl),
  .lead        (lead_sel),
  .data_valid  (data_valid),
  .wait_o      (wait_o)
);

// File: tb/burst_wait_gen_tb.sv
module burst_wait_gen_tb;
  localparam int ADDR_W = 23;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0;
  logic              cfg_wr_pol = 1'b1;
  logic              cfg_wr_lead = 1'b1;
  logic [2:0]        cfg_wr_lat = 3'd3;
  logic              sync_mode = 1'b1;
  logic              chip_en = 1'b0;
  logic              burst_start = 1'b0;
  logic [ADDR_W-1:0] start_addr = '0;
  logic              refresh_req = 1'b0;
  logic              data_valid;
  logic              wait_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  burst_wait_gen #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wr_pol(cfg_wr_pol),
    .cfg_wr_lead(cfg_wr_lead), .cfg_wr_lat(cfg_wr_lat), .sync_mode(sync_mode),
    .chip_en(chip_en), .burst_start(burst_start), .start_addr(start_addr),
    .refresh_req(refresh_req), .data_valid(data_valid), .wait_o(wait_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic lvl(input logic asrt, input logic pol);
    return pol ? asrt : !asrt;
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic write_cfg(input logic pol, input logic lead, input logic [2:0] lat);
    cfg_wr_pol = pol; cfg_wr_lead = lead; cfg_wr_lat = lat; cfg_we = 1'b1;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic start_burst(input logic [ADDR_W-1:0] a);
    start_addr = a; burst_start = 1'b1;
    tick();
    burst_start = 1'b0;
  endtask

  task automatic end_burst();
    chip_en = 1'b0;
    tick();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; chip_en = 1'b0; sync_mode = 1'b1;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("R1 dv after reset", data_valid, 1'b0);
    chk("R1 wait deasserted after reset", wait_o, 1'b0);
    sync_mode = 1'b0; #1;
    chk("R1 default polarity high in async", wait_o, 1'b1);
    sync_mode = 1'b1;
    tick();
  endtask

  // default config: leading, latency 3
  task automatic t_default_latency();
    chip_en = 1'b1;
    chk("R4 idle wait deasserted", wait_o, 1'b0);
    start_burst('0);
    for (int n = 0; n < 6; n++) begin
      chk($sformatf("R3 dv n=%0d", n), data_valid, n >= 3);
      chk($sformatf("R4 lead wait n=%0d", n), wait_o, n < 2);
      tick();
    end
    end_burst();
    chk("R10 dv after ce low", data_valid, 1'b0);
    chk("R10 wait after ce low", wait_o, 1'b0);
  endtask

  task automatic t_aligned();
    write_cfg(1'b1, 1'b0, 3'd4);
    chip_en = 1'b1;
    start_burst('0);
    for (int n = 0; n < 7; n++) begin
      chk($sformatf("R2 R3 dv lat4 n=%0d", n), data_valid, n >= 4);
      chk($sformatf("R5 aligned wait n=%0d", n), wait_o, (n >= 1) && (n < 4));
      tick();
    end
    end_burst();
  endtask

  task automatic t_row();
    write_cfg(1'b1, 1'b1, 3'd2);
    chip_en = 1'b1;
    start_burst(ADDR_W'(126));
    for (int n = 0; n < 7; n++) begin
      chk($sformatf("R6 dv n=%0d", n), data_valid, (n >= 2) && (n != 4));
      chk($sformatf("R6 wait n=%0d", n), wait_o, (n == 0) || (n == 3));
      tick();
    end
    end_burst();
  endtask

  task automatic t_refresh();
    write_cfg(1'b1, 1'b1, 3'd2);
    chip_en = 1'b1;
    start_burst(ADDR_W'(8));
    repeat (3) tick();
    refresh_req = 1'b1;
    tick();
    refresh_req = 1'b0;
    for (int n = 4; n < 10; n++) begin
      chk($sformatf("R7 dv n=%0d", n), data_valid, (n == 4) || (n == 9));
      chk($sformatf("R7 wait n=%0d", n), wait_o, n <= 7);
      tick();
    end
    end_burst();
    chip_en = 1'b1;
    refresh_req = 1'b1;
    tick();
    refresh_req = 1'b0;
    for (int n = 0; n < 3; n++) begin
      chk("R7 idle refresh ignored wait", wait_o, 1'b0);
      chk("R7 idle refresh ignored dv", data_valid, 1'b0);
      tick();
    end
    end_burst();
  endtask

  task automatic t_polarity();
    write_cfg(1'b0, 1'b1, 3'd2);
    chip_en = 1'b1;
    chk("R8 idle active-low deasserted", wait_o, lvl(1'b0, 1'b0));
    start_burst('0);
    chk("R8 asserted low n=0", wait_o, lvl(1'b1, 1'b0));
    tick();
    chk("R8 deasserted high n=1", wait_o, lvl(1'b0, 1'b0));
    sync_mode = 1'b0; #1;
    chk("R9 async asserted level active-low", wait_o, 1'b0);
    tick();
    sync_mode = 1'b1;
    end_burst();
  endtask

  task automatic t_async();
    write_cfg(1'b1, 1'b1, 3'd2);
    sync_mode = 1'b0;
    chip_en = 1'b1;
    start_burst('0);
    for (int n = 0; n < 5; n++) begin
      chk($sformatf("R9 async dv n=%0d", n), data_valid, 1'b0);
      chk($sformatf("R9 async wait n=%0d", n), wait_o, 1'b1);
      tick();
    end
    sync_mode = 1'b1;
    end_burst();
  endtask

  task automatic t_lat_limits();
    write_cfg(1'b1, 1'b1, 3'd0);
    chip_en = 1'b1;
    start_burst('0);
    for (int n = 0; n < 4; n++) begin
      chk($sformatf("R3 clamp dv n=%0d", n), data_valid, n >= 2);
      chk($sformatf("R4 clamp wait n=%0d", n), wait_o, n < 1);
      tick();
    end
    end_burst();
    write_cfg(1'b1, 1'b1, 3'd7);
    chip_en = 1'b1;
    start_burst('0);
    for (int n = 0; n < 9; n++) begin
      chk($sformatf("R3 lat7 dv n=%0d", n), data_valid, n >= 7);
      chk($sformatf("R4 lat7 wait n=%0d", n), wait_o, n < 6);
      tick();
    end
    end_burst();
  endtask

  initial begin
    t_reset();
    t_default_latency();
    t_aligned();
    t_row();
    t_refresh();
    t_polarity();
    t_async();
    t_lat_limits();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule